// File: doc/BRIEF.md
# Low-Storage Store Guard and Prefix Page Swapper

This block sits in the address path of a processor's storage interface, after logical-to-real translation. Each cycle it takes one real address, the access kind (read, store or instruction fetch) and a few control bits. It decides whether a store falls on the guarded bytes at the bottom of storage. If it does, it raises a protection fault with an exception code built from the page address and two indication flags. Otherwise it converts the real address to an absolute address. It does this by exchanging the first two 4 KiB pages of storage with the two pages that start at the prefix base.

The guard covers the first 512 bytes of page zero and the first 512 bytes of page one. It is switched on by a low-protection enable. When address translation is on, it is also switched off by the private-space bit of the selected address-space descriptor. When the page holding an address lies in a guarded page while the guard is on, the result carries a write-invalidate mark. This mark is set even when no fault is raised, so that a translation cache does not keep write permission for that page.

Every result is registered once. The outputs reflect the inputs that were present at the previous rising clock edge. There is no handshake.

Top module: `lowstore_guard_remap`

## Requirements
- R1: A store (access code 2'b01) with the guard on faults exactly when its address is in 0..511 or 4096..4607. Store addresses 512..4095 and 4608 and above do not fault.
- R2: When the low-protection enable is 0, no fault is raised and the write-invalidate mark is 0, for any address or access.
- R3: When translation is on and the private-space bit is 1, the guard is off: no fault and no write-invalidate mark. When translation is off, the private-space bit has no effect.
- R4: Only access code 2'b01 can fault. Read (2'b00), fetch (2'b10) and the unused code 2'b11 never fault, even on guarded bytes.
- R5: With the guard on, the write-invalidate mark is 1 whenever address bits [63:12] equal 0 or 1, for every access kind, and it is 0 otherwise. A fault always carries the mark.
- R6: On a fault, the exception code equals the address with bits [11:0] cleared, ORed with 12'h480 (bit 10 = store, bit 7 = low-storage indication), and the absolute address output is 0. Without a fault the exception code is 0.
- R7: Without a fault, a real address below 0x2000 maps to prefix plus address. An address from prefix to prefix+0x1FFF maps to address minus prefix. Any other address passes through unchanged. A prefix of 0 gives the identity.
- R8: Prefix base bits [12:0] are ignored. The prefix is treated as 8 KiB aligned.
- R9: All outputs are 0 during reset. A result appears one clock edge after its inputs are sampled, and it holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_addr | input | 64 | Real address |
| in_acc | input | 2 | Access kind: 00 read, 01 store, 10 fetch, 11 unused |
| lp_enable | input | 1 | Low-storage protection enable |
| xlate_on | input | 1 | Address translation mode is on |
| space_private | input | 1 | Private-space bit of the selected address-space descriptor |
| prefix_base | input | 64 | Prefix base; bits [12:0] ignored |
| out_abs_addr | output | 64 | Absolute address (0 on fault) |
| out_fault | output | 1 | Protection fault |
| out_exc_code | output | 64 | Translation-exception code (0 without fault) |
| out_wr_inval | output | 1 | Write permission must not be cached for this page |

## Verification
A wrong window bound in the guard shows at the ports as a fault, or a missing fault, on a store at 511/512 or 4607/4608. A wrong page compare shows as a missing or extra write-invalidate mark on a read in page one or page two. A wrong prefix comparison or a wrong swap direction shows as a corrupted absolute address at the 0x1FFF/0x2000 edge, or at prefix±1. Because the path is a single register stage, each of these errors appears on the result one edge after the offending input, and never later.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_t;

  localparam int unsigned STORE_FLAG_BIT = 10;
  localparam int unsigned LOWPROT_FLAG_BIT = 7;
  localparam logic [11:0] CODE_FLAGS =
    12'((1 << STORE_FLAG_BIT) | (1 << LOWPROT_FLAG_BIT));

endpackage

// File: rtl/lsg_window_check.sv
module lsg_window_check #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned WIN_BYTES = 512,
  parameter int unsigned WIN_COUNT = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              byte_hit_o,
  output logic              page_hit_o
);

  localparam int unsigned PN_W = ADDR_W - PAGE_BITS;
  localparam logic [PAGE_BITS-1:0] WIN_LIM = PAGE_BITS'(WIN_BYTES);

  logic [PN_W-1:0]      page_num;
  logic [PAGE_BITS-1:0] page_off;
  logic [WIN_COUNT-1:0] page_match;
  logic [WIN_COUNT-1:0] byte_match;

  assign page_num = addr_i[ADDR_W-1:PAGE_BITS];
  assign page_off = addr_i[PAGE_BITS-1:0];

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    assign page_match[w] = (page_num == PN_W'(w));
    assign byte_match[w] = page_match[w] && (page_off < WIN_LIM);
  end

  assign page_hit_o = |page_match;
  assign byte_hit_o = |byte_match;

endmodule

// File: rtl/lsg_prefix_swap.sv
module lsg_prefix_swap #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned SWAP_PAGES = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] prefix_i,
  output logic [ADDR_W-1:0] abs_o,
  output logic              hit_low_o,
  output logic              hit_pfx_o
);

  localparam int unsigned SWAP_BITS = PAGE_BITS + $clog2(SWAP_PAGES);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << SWAP_BITS) - 64'd1);

  logic [ADDR_W-1:0] base;

  function automatic logic [ADDR_W-1:0] swap_addr(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] b,
    input logic              lo,
    input logic              pf
  );
    if (lo)      return a + b;
    else if (pf) return a - b;
    else         return a;
  endfunction

  assign base      = prefix_i & ~LOW_MASK;
  assign hit_low_o = ((addr_i & ~LOW_MASK) == '0);
  assign hit_pfx_o = ((addr_i & ~LOW_MASK) == base);
  assign abs_o     = swap_addr(addr_i, base, hit_low_o, hit_pfx_o);

endmodule

// File: rtl/lowstore_guard_remap.sv
module lowstore_guard_remap
  import lsg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned WIN_BYTES  = 512,
  parameter int unsigned WIN_COUNT  = 2,
  parameter int unsigned SWAP_PAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_acc,
  input  logic              lp_enable,
  input  logic              xlate_on,
  input  logic              space_private,
  input  logic [ADDR_W-1:0] prefix_base,
  output logic [ADDR_W-1:0] out_abs_addr,
  output logic              out_fault,
  output logic [ADDR_W-1:0] out_exc_code,
  output logic              out_wr_inval
);

  localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

  logic              guard_on;
  logic              byte_in_window;
  logic              page_in_window;
  logic              is_store;
  logic              store_fault;
  logic              inval_next;
  logic [ADDR_W-1:0] swapped_addr;
  logic              hit_low_pages;
  logic              hit_prefix_pages;
  logic [ADDR_W-1:0] code_next;
  logic [ADDR_W-1:0] abs_next;

  function automatic logic [ADDR_W-1:0] make_code(input logic [ADDR_W-1:0] a);
    return (a & PAGE_MASK) | ADDR_W'(CODE_FLAGS);
  endfunction

  lsg_window_check #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .WIN_BYTES(WIN_BYTES), .WIN_COUNT(WIN_COUNT)
  ) u_win (
    .addr_i(in_addr),
    .byte_hit_o(byte_in_window),
    .page_hit_o(page_in_window)
  );

  lsg_prefix_swap #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SWAP_PAGES(SWAP_PAGES)
  ) u_swap (
    .addr_i(in_addr),
    .prefix_i(prefix_base),
    .abs_o(swapped_addr),
    .hit_low_o(hit_low_pages),
    .hit_pfx_o(hit_prefix_pages)
  );

  assign guard_on    = lp_enable && !(xlate_on && space_private);
  assign is_store    = (acc_t'(in_acc) == ACC_STORE);
  assign store_fault = guard_on && is_store && byte_in_window;
  assign inval_next  = guard_on && page_in_window;
  assign code_next   = store_fault ? make_code(in_addr) : '0;
  assign abs_next    = store_fault ? '0 : swapped_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_abs_addr <= '0;
      out_fault    <= 1'b0;
      out_exc_code <= '0;
      out_wr_inval <= 1'b0;
    end else begin
      out_abs_addr <= abs_next;
      out_fault    <= store_fault;
      out_exc_code <= code_next;
      out_wr_inval <= inval_next;
    end
  end

  AST_FAULT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> $past(lp_enable)); // R2
  AST_PRIVATE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xlate_on && space_private) |-> (!out_fault && !out_wr_inval)); // R3
  AST_FAULT_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> ($past(in_acc) == 2'b01)); // R4
  AST_FAULT_MARKS_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_wr_inval); // R5
  AST_CODE_ZERO_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_fault |-> (out_exc_code == '0)); // R6
  AST_ABS_ZERO_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_abs_addr == '0)); // R6
  AST_SWAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_low_pages && hit_prefix_pages) |-> (swapped_addr == in_addr)); // R7

endmodule

// File: tb/sim_lowstore_guard_remap.sv
module sim_lowstore_guard_remap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] in_addr = '0;
  logic [1:0]  in_acc = '0;
  logic        lp_enable = 1'b0;
  logic        xlate_on = 1'b0;
  logic        space_private = 1'b0;
  logic [63:0] prefix_base = '0;
  logic [63:0] out_abs_addr;
  logic        out_fault;
  logic [63:0] out_exc_code;
  logic        out_wr_inval;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] prev_abs = '0;

  always #2.5 clk = ~clk;

  lowstore_guard_remap u0 (
    .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .in_acc(in_acc),
    .lp_enable(lp_enable), .xlate_on(xlate_on), .space_private(space_private),
    .prefix_base(prefix_base), .out_abs_addr(out_abs_addr), .out_fault(out_fault),
    .out_exc_code(out_exc_code), .out_wr_inval(out_wr_inval)
  );

  function automatic bit guarded_byte(input logic [63:0] a);
    return (a < 64'd512) || (a >= 64'd4096 && a < 64'd4608);
  endfunction

  function automatic bit guard_live(input bit en, input bit xl, input bit pv);
    if (!en) return 1'b0;
    if (xl && pv) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [63:0] model_abs(input logic [63:0] a, input logic [63:0] pre);
    logic [63:0] p;
    p = {pre[63:13], 13'd0};
    if (a < 64'h2000) return a + p;
    if (a >= p && (a - p) < 64'h2000) return a - p;
    return a;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [63:0] a, input logic [1:0] acc,
                       input bit en, input bit xl, input bit pv, input logic [63:0] pre);
    bit f, inv;
    logic [63:0] code, absv;
    @(negedge clk);
    in_addr = a; in_acc = acc; lp_enable = en; xlate_on = xl;
    space_private = pv; prefix_base = pre;
    #1;
    chk("R9", "abs held before edge", out_abs_addr, prev_abs);
    f    = guard_live(en, xl, pv) && (acc == 2'b01) && guarded_byte(a);
    inv  = guard_live(en, xl, pv) && (a < 64'h2000);
    code = f ? ((a >> 12) << 12) + 64'h480 : 64'd0;
    absv = f ? 64'd0 : model_abs(a, pre);
    @(posedge clk);
    #1;
    chk(tag, "fault", {63'd0, out_fault}, {63'd0, f});
    chk(tag, "wr_inval", {63'd0, out_wr_inval}, {63'd0, inv});
    chk(tag, "exc_code", out_exc_code, code);
    chk(tag, "abs_addr", out_abs_addr, absv);
    prev_abs = absv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] pfx;
    logic [63:0] a;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset abs", out_abs_addr, 64'd0);
    chk("R9", "reset fault", {63'd0, out_fault}, 64'd0);
    chk("R9", "reset code", out_exc_code, 64'd0);
    chk("R9", "reset inval", {63'd0, out_wr_inval}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    pfx = 64'h0000_0000_0034_6000;
    apply("R1 store 0", 64'd0, 2'b01, 1, 0, 0, pfx);
    apply("R1 store 511", 64'd511, 2'b01, 1, 0, 0, pfx);
    apply("R1 store 512", 64'd512, 2'b01, 1, 0, 0, pfx);
    apply("R1 store 4095", 64'd4095, 2'b01, 1, 0, 0, pfx);
    apply("R1 store 4096", 64'd4096, 2'b01, 1, 0, 0, pfx);
    apply("R1 store 4607", 64'd4607, 2'b01, 1, 0, 0, pfx);
    apply("R1 store 4608", 64'd4608, 2'b01, 1, 0, 0, pfx);
    apply("R5 read 8191", 64'd8191, 2'b00, 1, 0, 0, pfx);
    apply("R5 read 8192", 64'd8192, 2'b00, 1, 0, 0, pfx);
    apply("R2 disabled", 64'd100, 2'b01, 0, 0, 0, pfx);
    apply("R3 private xlate", 64'd100, 2'b01, 1, 1, 1, pfx);
    apply("R3 private no xlate", 64'd100, 2'b01, 1, 0, 1, pfx);
    apply("R3 xlate shared", 64'd4100, 2'b01, 1, 1, 0, pfx);
    apply("R4 read guarded", 64'd5, 2'b00, 1, 0, 0, pfx);
    apply("R4 fetch guarded", 64'd4200, 2'b10, 1, 0, 0, pfx);
    apply("R4 code3 guarded", 64'd300, 2'b11, 1, 0, 0, pfx);
    apply("R7 prefix start", pfx, 2'b01, 1, 0, 0, pfx);
    apply("R7 prefix end", pfx + 64'h1FFF, 2'b00, 1, 0, 0, pfx);
    apply("R7 past prefix", pfx + 64'h2000, 2'b00, 1, 0, 0, pfx);
    apply("R7 below prefix", pfx - 64'd1, 2'b00, 1, 0, 0, pfx);
    apply("R7 prefix zero", 64'h1ABC, 2'b00, 1, 0, 0, 64'd0);
    apply("R8 prefix low bits", 64'h0800, 2'b00, 1, 0, 0, pfx | 64'h1FFF);
    apply("R8 prefix low bits hit", pfx + 64'h10, 2'b00, 0, 0, 0, pfx | 64'h0F0F);
    apply("R6 high page code", 64'h1234, 2'b01, 1, 0, 0, 64'hFFFF_FFFF_FFFF_E000);
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] acc;
      case ($urandom % 4)
        0: pfx = 64'd0;
        1: pfx = {$urandom, $urandom};
        default: pfx = {32'd0, $urandom} & 64'h0000_0000_00FF_FFFF;
      endcase
      case ($urandom % 4)
        0: a = {52'd0, 12'($urandom)} | (($urandom % 2 == 0) ? 64'd0 : 64'h1000);
        1: a = {pfx[63:13], 13'd0} + {51'd0, 13'($urandom)};
        2: a = {$urandom, $urandom};
        default: a = ((($urandom % 2) == 0) ? 64'd512 : 64'd4608) + 64'($urandom % 5) - 64'd2;
      endcase
      acc = 2'($urandom);
      apply("R1 R5 R6 R7 random", a, acc, 1'($urandom), 1'($urandom), 1'($urandom), pfx);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule